// File: doc/BRIEF.md
# Seven-Level Space-Vector Triangle Locator

This block sits in the modulator path of a multilevel three-phase inverter. It takes a sampled reference vector each clock: its angle, and its two orthogonal components already rotated into the first sector, in signed fixed point scaled so that one small triangle of the space-vector diagram has unit side. It returns the 60-degree sector, the small triangle that holds the tip of the vector, whether that triangle points up or down, and the three dwell times of one half switching period counted in clock ticks.

Each small triangle is handled as one sector of a two-level hexagon. Two integer row indices, taken along directions 120 degrees apart, pick a rhombus. A slope test against the rhombus diagonal splits that rhombus into its two triangles. The same dwell equations are then evaluated on the vector's coordinates relative to the rhombus origin. The pipeline accepts one sample per cycle and has a fixed latency. A later stage maps the triangle and dwell times to switch states.

Top module: `sv_triangle_locator`

## Requirements
- R1: With the angle in units of 1/64 degree and 3840 units per sector, `out_sector` = 1 + floor(angle/3840), held at 6 for any angle of 19200 or more.
- R2: Components are Q4.12 (value = code/4096). The row indices are I1 = (α + ((β·2365) >>> 12)) >>> 12 and I2 = (β·4730) >>> 24, with arithmetic (flooring) shifts.
- R3: With local coordinates VαS = α − 4096·I1 + 2048·I2 and VβS = β − 3547·I2, `out_upper` is 1 exactly when 4096·VβS > 7094·VαS, and 0 otherwise.
- R4: `out_tri_idx` = I1² + 2·I2 + `out_upper`.
- R5: With TS = 5000 ticks, the unsaturated times are Ta = (TS·(4096·VαS − 2365·VβS)) >>> 24 and Tb = (TS·4730·VβS) >>> 24.
- R6: A negative Ta or Tb is output as 0. Ta is capped at TS, and Tb is capped at TS − Ta.
- R7: `out_t0` = TS − `out_ta` − `out_tb`, so the three times always sum to TS.
- R8: A sample presented with `in_valid` high before a rising edge produces a result with `out_valid` high after the fourth rising edge from that one. Back-to-back samples come out back to back, and `out_valid` is low in every cycle that has no sample four edges earlier.
- R9: While `rst` (synchronous, active high) is asserted, `out_valid` and every output field read 0.
- R10: I1 and I2 are clamped to the range 0 to 5. A negative index becomes 0 and an index above 5 becomes 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_angle | input | 16 | Reference angle, 1/64 degree per code |
| in_alpha | input | 16 | Sector-local α component, signed Q4.12 |
| in_beta | input | 16 | Sector-local β component, signed Q4.12 |
| out_valid | output | 1 | Result strobe |
| out_sector | output | 3 | Sector number, 1 to 6 |
| out_tri_idx | output | 6 | Triangle index within the sector |
| out_upper | output | 1 | 1 when the triangle's base is at the top |
| out_ta | output | 13 | First active dwell, ticks |
| out_tb | output | 13 | Second active dwell, ticks |
| out_t0 | output | 13 | Zero-vector dwell, ticks |

## Verification
The bench builds the block with its defaults: seven levels, 5000 ticks per half period and 3840 angle codes per sector. With these values, every row of the diagram, both clamp limits of the row indices and the last sector boundary can be reached with short directed vectors. The 16-bit angle can also go past 360 degrees, which exercises the hold at sector 6. Hand-worked vectors are checked next to a bench model of the requirement formulas, and a continuous stream with gaps tests the fixed latency.

// File: rtl/svtl_pkg.sv
package svtl_pkg;
    // Fixed-point constants for Q.12 coordinates
    localparam int FRAC   = 12;
    localparam int ONE    = 1 << FRAC;
    localparam int HALF   = ONE / 2;
    localparam int K_RSQ3 = 2365;   // 1/sqrt(3)
    localparam int K_RH   = 4730;   // 1/h = 2/sqrt(3)
    localparam int K_H    = 3547;   // h = sqrt(3)/2
    localparam int K_SQ3  = 7094;   // sqrt(3)

    function automatic int clamp_row(input int raw, input int top);
        if (raw < 0)
            return 0;
        else if (raw > top)
            return top;
        else
            return raw;
    endfunction
endpackage

// File: rtl/svtl_sector.sv
module svtl_sector #(
    parameter int ANG_W      = 16,
    parameter int ANG_SECTOR = 3840
) (
    input  logic [ANG_W-1:0] angle,
    output logic [2:0]       sector
);
    logic [4:0] crossed;

    // One comparator per sector boundary
    for (genvar k = 1; k <= 5; k++) begin : g_edge
        assign crossed[k-1] = (64'(angle) >= 64'(k * ANG_SECTOR));
    end

    always_comb begin
        sector = 3'd1 + 3'($countones(crossed));
    end
endmodule

// File: rtl/svtl_region.sv
module svtl_region
    import svtl_pkg::*;
#(
    parameter int IN_W   = 16,
    parameter int LEVELS = 7,
    parameter int IW     = 3
) (
    input  logic signed [IN_W-1:0] alpha,
    input  logic signed [IN_W-1:0] beta,
    output logic [IW-1:0]          i1,
    output logic [IW-1:0]          i2
);
    localparam int ROW_TOP = LEVELS - 2;

    longint a64;
    longint b64;
    longint skew;
    longint raw1;
    longint raw2;

    always_comb begin
        a64  = longint'(alpha);
        b64  = longint'(beta);
        skew = a64 + ((b64 * K_RSQ3) >>> FRAC);
        raw1 = skew >>> FRAC;
        raw2 = (b64 * K_RH) >>> (2 * FRAC);
        i1   = IW'(clamp_row(int'(raw1), ROW_TOP));
        i2   = IW'(clamp_row(int'(raw2), ROW_TOP));
    end
endmodule

// File: rtl/svtl_classify.sv
module svtl_classify
    import svtl_pkg::*;
#(
    parameter int CW       = 20,
    parameter int IW       = 3,
    parameter int IDX_W    = 6,
    parameter int TS_TICKS = 5000
) (
    input  logic [IW-1:0]          i1,
    input  logic [IW-1:0]          i2,
    input  logic signed [CW-1:0]   vas,
    input  logic signed [CW-1:0]   vbs,
    output logic                   upper,
    output logic [IDX_W-1:0]       idx,
    output logic signed [31:0]     ta_raw,
    output logic signed [31:0]     tb_raw
);
    longint x;
    longint y;
    longint rise;
    longint diag;
    longint pa;
    longint pb;

    always_comb begin
        x      = longint'(vas);
        y      = longint'(vbs);
        // Slope of the local vector against the rhombus diagonal
        rise   = y * ONE;
        diag   = x * K_SQ3;
        upper  = (rise > diag);
        idx    = IDX_W'(int'(i1) * int'(i1) + 2 * int'(i2) + int'(upper));
        pa     = longint'(TS_TICKS) * (x * ONE - y * K_RSQ3);
        pb     = longint'(TS_TICKS) * y * K_RH;
        ta_raw = 32'(pa >>> (2 * FRAC));
        tb_raw = 32'(pb >>> (2 * FRAC));
    end
endmodule

// File: rtl/svtl_dwell.sv
module svtl_dwell #(
    parameter int TS_TICKS = 5000,
    parameter int TW       = 13
) (
    input  logic signed [31:0] ta_raw,
    input  logic signed [31:0] tb_raw,
    output logic [TW-1:0]      ta,
    output logic [TW-1:0]      tb,
    output logic [TW-1:0]      t0
);
    int a_sat;
    int b_room;
    int b_sat;

    always_comb begin
        if (ta_raw < 0)
            a_sat = 0;
        else if (ta_raw > TS_TICKS)
            a_sat = TS_TICKS;
        else
            a_sat = int'(ta_raw);

        b_room = TS_TICKS - a_sat;
        if (tb_raw < 0)
            b_sat = 0;
        else if (tb_raw > b_room)
            b_sat = b_room;
        else
            b_sat = int'(tb_raw);

        ta = TW'(a_sat);
        tb = TW'(b_sat);
        t0 = TW'(TS_TICKS - a_sat - b_sat);
    end
endmodule

// File: rtl/sv_triangle_locator.sv
module sv_triangle_locator
    import svtl_pkg::*;
#(
    parameter int LEVELS     = 7,
    parameter int TS_TICKS   = 5000,
    parameter int IN_W       = 16,
    parameter int ANG_W      = 16,
    parameter int ANG_SECTOR = 3840,
    localparam int IW        = $clog2(LEVELS),
    localparam int IDX_W     = $clog2((LEVELS - 1) * (LEVELS - 1) + 1),
    localparam int TW        = $clog2(TS_TICKS + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [ANG_W-1:0]       in_angle,
    input  logic signed [IN_W-1:0] in_alpha,
    input  logic signed [IN_W-1:0] in_beta,
    output logic                   out_valid,
    output logic [2:0]             out_sector,
    output logic [IDX_W-1:0]       out_tri_idx,
    output logic                   out_upper,
    output logic [TW-1:0]          out_ta,
    output logic [TW-1:0]          out_tb,
    output logic [TW-1:0]          out_t0
);
    localparam int CW = IN_W + 4;

    typedef struct packed {
        logic                   v;
        logic [2:0]             sec;
        logic signed [IN_W-1:0] va;
        logic signed [IN_W-1:0] vb;
        logic [IW-1:0]          i1;
        logic [IW-1:0]          i2;
    } row_stage_t;

    typedef struct packed {
        logic                 v;
        logic [2:0]           sec;
        logic [IW-1:0]        i1;
        logic [IW-1:0]        i2;
        logic signed [CW-1:0] vas;
        logic signed [CW-1:0] vbs;
    } local_stage_t;

    typedef struct packed {
        logic               v;
        logic [2:0]         sec;
        logic               up;
        logic [IDX_W-1:0]   idx;
        logic signed [31:0] ta_raw;
        logic signed [31:0] tb_raw;
    } class_stage_t;

    typedef struct packed {
        logic             v;
        logic [2:0]       sec;
        logic             up;
        logic [IDX_W-1:0] idx;
        logic [TW-1:0]    ta;
        logic [TW-1:0]    tb;
        logic [TW-1:0]    t0;
    } out_stage_t;

    typedef struct packed {
        row_stage_t   s1;
        local_stage_t s2;
        class_stage_t s3;
        out_stage_t   s4;
    } pipe_t;

    pipe_t pipe_d;
    pipe_t pipe_q;

    logic [2:0]         sec_in;
    logic [IW-1:0]      i1_in;
    logic [IW-1:0]      i2_in;
    logic               up_c;
    logic [IDX_W-1:0]   idx_c;
    logic signed [31:0] ta_raw_c;
    logic signed [31:0] tb_raw_c;
    logic [TW-1:0]      ta_c;
    logic [TW-1:0]      tb_c;
    logic [TW-1:0]      t0_c;

    svtl_sector #(
        .ANG_W      (ANG_W),
        .ANG_SECTOR (ANG_SECTOR)
    ) u_sector (
        .angle  (in_angle),
        .sector (sec_in)
    );

    svtl_region #(
        .IN_W   (IN_W),
        .LEVELS (LEVELS),
        .IW     (IW)
    ) u_region (
        .alpha (in_alpha),
        .beta  (in_beta),
        .i1    (i1_in),
        .i2    (i2_in)
    );

    svtl_classify #(
        .CW       (CW),
        .IW       (IW),
        .IDX_W    (IDX_W),
        .TS_TICKS (TS_TICKS)
    ) u_classify (
        .i1     (pipe_q.s2.i1),
        .i2     (pipe_q.s2.i2),
        .vas    (pipe_q.s2.vas),
        .vbs    (pipe_q.s2.vbs),
        .upper  (up_c),
        .idx    (idx_c),
        .ta_raw (ta_raw_c),
        .tb_raw (tb_raw_c)
    );

    svtl_dwell #(
        .TS_TICKS (TS_TICKS),
        .TW       (TW)
    ) u_dwell (
        .ta_raw (pipe_q.s3.ta_raw),
        .tb_raw (pipe_q.s3.tb_raw),
        .ta     (ta_c),
        .tb     (tb_c),
        .t0     (t0_c)
    );

    always_comb begin
        pipe_d = pipe_q;

        // Stage 1: sector and row indices
        pipe_d.s1.v   = in_valid;
        pipe_d.s1.sec = sec_in;
        pipe_d.s1.va  = in_alpha;
        pipe_d.s1.vb  = in_beta;
        pipe_d.s1.i1  = i1_in;
        pipe_d.s1.i2  = i2_in;

        // Stage 2: coordinates relative to the rhombus origin
        pipe_d.s2.v   = pipe_q.s1.v;
        pipe_d.s2.sec = pipe_q.s1.sec;
        pipe_d.s2.i1  = pipe_q.s1.i1;
        pipe_d.s2.i2  = pipe_q.s1.i2;
        pipe_d.s2.vas = CW'(int'($signed(pipe_q.s1.va))
                            - int'(pipe_q.s1.i1) * ONE
                            + int'(pipe_q.s1.i2) * HALF);
        pipe_d.s2.vbs = CW'(int'($signed(pipe_q.s1.vb))
                            - int'(pipe_q.s1.i2) * K_H);

        // Stage 3: triangle type, index and raw dwell times
        pipe_d.s3.v      = pipe_q.s2.v;
        pipe_d.s3.sec    = pipe_q.s2.sec;
        pipe_d.s3.up     = up_c;
        pipe_d.s3.idx    = idx_c;
        pipe_d.s3.ta_raw = ta_raw_c;
        pipe_d.s3.tb_raw = tb_raw_c;

        // Stage 4: saturated dwell times
        pipe_d.s4.v   = pipe_q.s3.v;
        pipe_d.s4.sec = pipe_q.s3.sec;
        pipe_d.s4.up  = pipe_q.s3.up;
        pipe_d.s4.idx = pipe_q.s3.idx;
        pipe_d.s4.ta  = ta_c;
        pipe_d.s4.tb  = tb_c;
        pipe_d.s4.t0  = t0_c;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pipe_q <= '0;
        else
            pipe_q <= pipe_d;
    end

    assign out_valid   = pipe_q.s4.v;
    assign out_sector  = pipe_q.s4.sec;
    assign out_tri_idx = pipe_q.s4.idx;
    assign out_upper   = pipe_q.s4.up;
    assign out_ta      = pipe_q.s4.ta;
    assign out_tb      = pipe_q.s4.tb;
    assign out_t0      = pipe_q.s4.t0;
endmodule

// File: rtl/svtl_checker.sv
module svtl_checker #(
    parameter int LEVELS   = 7,
    parameter int TS_TICKS = 5000,
    parameter int IDX_W    = 6,
    parameter int TW       = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [2:0]       out_sector,
    input logic [IDX_W-1:0] out_tri_idx,
    input logic [TW-1:0]    out_ta,
    input logic [TW-1:0]    out_tb,
    input logic [TW-1:0]    out_t0
);
    localparam int ROW_TOP = LEVELS - 2;
    localparam int IDX_TOP = ROW_TOP * ROW_TOP + 2 * ROW_TOP + 1;

    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst < 3'd4)
            since_rst <= since_rst + 3'd1;
    end

    AST_SECTOR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sector >= 3'd1 && out_sector <= 3'd6)); // R1

    AST_INDEX_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(out_tri_idx) <= IDX_TOP)); // R4

    AST_TB_WITHIN_SLOT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(out_ta) + int'(out_tb) <= TS_TICKS)); // R6

    AST_SLOT_FILLED: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(out_ta) + int'(out_tb) + int'(out_t0) == TS_TICKS)); // R7

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4))); // R8
endmodule

bind sv_triangle_locator svtl_checker #(
    .LEVELS   (LEVELS),
    .TS_TICKS (TS_TICKS),
    .IDX_W    (IDX_W),
    .TW       (TW)
) u_chk (.*);

// File: tb/sim_sv_triangle_locator.sv
`timescale 1ns/1ps
module sim_sv_triangle_locator;
    localparam int TS = 5000;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [15:0]        in_angle = '0;
    logic signed [15:0] in_alpha = '0;
    logic signed [15:0] in_beta = '0;
    logic               out_valid;
    logic [2:0]         out_sector;
    logic [5:0]         out_tri_idx;
    logic               out_upper;
    logic [12:0]        out_ta;
    logic [12:0]        out_tb;
    logic [12:0]        out_t0;

    sv_triangle_locator u0 (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_angle    (in_angle),
        .in_alpha    (in_alpha),
        .in_beta     (in_beta),
        .out_valid   (out_valid),
        .out_sector  (out_sector),
        .out_tri_idx (out_tri_idx),
        .out_upper   (out_upper),
        .out_ta      (out_ta),
        .out_tb      (out_tb),
        .out_t0      (out_t0)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Expected-result queue
    int    e_sec [64];
    int    e_idx [64];
    int    e_up  [64];
    int    e_ta  [64];
    int    e_tb  [64];
    int    e_t0  [64];
    int    e_due [64];
    string e_tag [64];
    int    wr = 0;
    int    rd = 0;

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    // Bench model of the requirement formulas (R1..R7, R10)
    task automatic model(input int ang, input int va, input int vb,
                         output int sec, output int idx, output int up,
                         output int ta, output int tb, output int t0);
        longint s1, r1, r2, i1, i2, vas, vbs, a, b;
        sec = ang / 3840 + 1;
        if (sec > 6) sec = 6;
        s1 = longint'(va) + ((longint'(vb) * 2365) >>> 12);
        r1 = s1 >>> 12;
        r2 = (longint'(vb) * 4730) >>> 24;
        i1 = (r1 < 0) ? 0 : ((r1 > 5) ? 5 : r1);
        i2 = (r2 < 0) ? 0 : ((r2 > 5) ? 5 : r2);
        vas = longint'(va) - 4096 * i1 + 2048 * i2;
        vbs = longint'(vb) - 3547 * i2;
        up  = (vbs * 4096 > vas * 7094) ? 1 : 0;
        idx = int'(i1 * i1 + 2 * i2) + up;
        a = (longint'(TS) * (vas * 4096 - vbs * 2365)) >>> 24;
        b = (longint'(TS) * vbs * 4730) >>> 24;
        if (a < 0) a = 0;
        if (a > TS) a = TS;
        if (b < 0) b = 0;
        if (b > TS - a) b = TS - a;
        ta = int'(a);
        tb = int'(b);
        t0 = TS - ta - tb;
    endtask

    task automatic push(input int sec, input int idx, input int up, input int ta,
                        input int tb, input int t0, input string tag);
        e_sec[wr % 64] = sec;
        e_idx[wr % 64] = idx;
        e_up[wr % 64]  = up;
        e_ta[wr % 64]  = ta;
        e_tb[wr % 64]  = tb;
        e_t0[wr % 64]  = t0;
        e_due[wr % 64] = cyc + 4;
        e_tag[wr % 64] = tag;
        wr++;
    endtask

    task automatic drive(input int ang, input int va, input int vb);
        in_angle = 16'(ang);
        in_alpha = 16'(va);
        in_beta  = 16'(vb);
        in_valid = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(input int ang, input int va, input int vb, input string tag);
        int sec, idx, up, ta, tb, t0;
        model(ang, va, vb, sec, idx, up, ta, tb, t0);
        push(sec, idx, up, ta, tb, t0, tag);
        drive(ang, va, vb);
    endtask

    task automatic send_exp(input int ang, input int va, input int vb, input int sec,
                            input int idx, input int up, input int ta, input int tb,
                            input int t0, input string tag);
        push(sec, idx, up, ta, tb, t0, tag);
        drive(ang, va, vb);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(input string what);
        idle(6);
        chk("R8", what, longint'(wr - rd), 0);
    endtask

    // Output monitor: compares each result with the queue head (R8 timing)
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (rd == wr) begin
                    chk("R8", "unexpected out_valid", 1, 0);
                end else begin
                    chk("R8", "result cycle", longint'(cyc), longint'(e_due[rd % 64]));
                    chk("R1", "sector", longint'(out_sector), longint'(e_sec[rd % 64]));
                    chk("R3", "upper", longint'(out_upper), longint'(e_up[rd % 64]));
                    chk(e_tag[rd % 64], "tri_idx", longint'(out_tri_idx), longint'(e_idx[rd % 64]));
                    chk(e_tag[rd % 64], "ta", longint'(out_ta), longint'(e_ta[rd % 64]));
                    chk(e_tag[rd % 64], "tb", longint'(out_tb), longint'(e_tb[rd % 64]));
                    chk("R7", "t0", longint'(out_t0), longint'(e_t0[rd % 64]));
                    rd++;
                end
            end else if (rd != wr && cyc >= e_due[rd % 64]) begin
                chk("R8", "missing out_valid", 0, 1);
                rd++;
            end
        end
    end

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R9", "out_valid in reset", longint'(out_valid), 0);
        chk("R9", "fields in reset",
            longint'({out_sector, out_tri_idx, out_upper, out_ta, out_tb, out_t0}), 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Hand-worked vectors
    task automatic t_hand();
        send_exp(0,    0,    0,    1, 0, 0, 0,    0,    5000, "R5");
        send_exp(600,  2048, 0,    1, 0, 0, 2500, 0,    2500, "R5");
        send_exp(1000, 0,    1638, 1, 1, 1, 0,    2309, 2691, "R6");
        send_exp(2000, 5120, 0,    1, 1, 0, 1250, 0,    3750, "R4");
        drain("hand vectors drained");
    endtask

    task automatic t_sectors();
        send(3839,  1000, 300, "R1");
        send(3840,  1000, 300, "R1");
        send(7680,  1000, 300, "R1");
        send(19199, 1000, 300, "R1");
        send(19200, 1000, 300, "R1");
        send(23039, 1000, 300, "R1");
        send(65535, 1000, 300, "R1");
        drain("sector sweep drained");
    endtask

    task automatic t_clamp();
        send(100, -2048, -1024, "R10");
        send(100, 32358, 32358, "R10");
        send(100, 27034, 0,     "R6");
        send(100, 24166, 410,   "R10");
        send(100, 3000,  -800,  "R6");
        drain("clamp vectors drained");
    endtask

    task automatic t_stream();
        for (int k = 0; k < 12; k++)
            send(k * 2000, k * 2048 + 300, (k * 1733) % 15000, "R2");
        idle(1);
        send(500, 9000, 6000, "R3");
        idle(2);
        send(500, 9000, 7100, "R3");
        send(500, 14000, 12000, "R2");
        drain("stream drained");
    endtask

    initial begin
        t_reset();
        t_hand();
        t_sectors();
        t_clamp();
        t_stream();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule